// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

A one-shot countdown timer meant to sit inside a local interrupt controller. Software programs a divide setting and then writes a start value; the block counts that value down at the input clock rate divided by a power of two and produces a single-cycle pulse when the count runs out. Software can read back the remaining count at any time, expressed in divided ticks and rounded up.

The divide ratio comes from a three-bit field whose bits are scattered across a four-bit register: bit 3 supplies the upper bit and bits 1:0 the lower two. The field value plus one, modulo 8, is the base-2 logarithm of the ratio, so the ratio runs from 1 to 128. A free-running prescaler phase counter starts at zero on reset. When a start value is written off a divided-tick boundary, the countdown is stretched to the next boundary, which adds up to one extra divided tick.

Access uses a plain strobe interface. The register addresses are 0 for the divide setting, 1 for the start value, 2 for the current count (read-only) and 3 reserved. A read strobe loads `reg_rdata` at the next clock edge, and the value is held until the next read.

Top module: `cdown_timer`

## Requirements
- R1: After reset `timer_expired` is low, and reads of addresses 0, 1, 2 and 3 all return 0.
- R2: The divide shift is s = ({cfg[3], cfg[1], cfg[0]} + 1) mod 8, and the ratio is D = 2^s. A cfg of 0 therefore gives D = 2, and a cfg with bits 3, 1 and 0 all set gives D = 1.
- R3: A write to address 0 keeps only bits 3, 1 and 0. Reading address 0 returns the kept bits, with every other bit zero.
- R4: A write of N to address 1 stores bits COUNT_W-1:0 of the data, which read back from address 1, and restarts the countdown. If the prescaler phase (input cycles since reset, modulo 128) is a multiple of D at the write edge, the countdown length L is N*D cycles.
- R5: If the phase p is not a multiple of D at the write edge, L = N*D + (D - p mod D).
- R6: `timer_expired` is high for exactly one cycle, during the cycle after the edge L cycles past the write edge. The timer is idle afterwards.
- R7: While the timer is running, a read of address 2 taken k edges after the write edge returns ceil((L-k+1)/D), saturated at 2^COUNT_W-1.
- R8: A read of address 2 while the timer is idle or has expired returns 0.
- R9: Writing 0 to address 1 stops a running countdown without any expiry pulse.
- R10: Writes to address 2 or address 3 change neither the countdown nor its expiry.
- R11: The divide setting is captured when address 1 is written. A later write to address 0 changes neither the running period nor the rounding of the readback.
- R12: A write to address 1 on the edge where expiry would occur suppresses that pulse and starts the new countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 divide, 1 start value, 2 current count, 3 reserved |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| timer_expired | output | 1 | One-cycle expiry pulse |

## Verification
Two events can land on the same edge: a countdown reaching its end and software writing a new start value. The bench provokes this by following a countdown to the cycle before its last one and then issuing a start write on the final edge. It judges the result by checking that no pulse appears and that the new countdown then expires exactly on its own computed cycle. Every divide code, including codes with the discarded bit 2 set, is swept with the write both on and off a divided-tick boundary. The pulse cycle and each cycle's rounded readback are predicted from the bench's own phase counter.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int SHIFT_W = 3;
  localparam int PHASE_W = (1 << SHIFT_W) - 1;

  typedef enum logic [1:0] {
    A_DIV  = 2'd0,
    A_INIT = 2'd1,
    A_CUR  = 2'd2,
    A_RSVD = 2'd3
  } cdt_addr_e;

  localparam logic [3:0] DIV_KEEP = 4'b1011;

  // Gather bit 3 and bits 1:0, add one with 3-bit wrap.
  function automatic logic [SHIFT_W-1:0] cdt_shift(input logic [3:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + SHIFT_W'(1);
  endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               rd,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [COUNT_W-1:0] cur_count,
  output logic [3:0]         cfg_q,
  output logic               load,
  output logic [COUNT_W-1:0] load_val,
  output logic [DATA_W-1:0]  rdata
);

  logic [COUNT_W-1:0] init_q;
  logic [DATA_W-1:0]  rd_mux;

  assign load     = wr && (cdt_addr_e'(addr) == A_INIT);
  assign load_val = wdata[COUNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      init_q <= '0;
    end else if (wr) begin
      case (cdt_addr_e'(addr))
        A_DIV:   cfg_q  <= wdata[3:0] & DIV_KEEP;
        A_INIT:  init_q <= wdata[COUNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (cdt_addr_e'(addr))
      A_DIV:   rd_mux[3:0]         = cfg_q;
      A_INIT:  rd_mux[COUNT_W-1:0] = init_q;
      A_CUR:   rd_mux[COUNT_W-1:0] = cur_count;
      default: rd_mux              = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int PHASE_W = 7,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SHIFT_W-1:0] shift,
  output logic [PHASE_W-1:0] pad
);

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] low_mask;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + PHASE_W'(1);
  end

  // Cycles left to the next divided-tick boundary: (-phase) mod D.
  assign low_mask = ~({PHASE_W{1'b1}} << shift);
  assign pad      = (~phase + PHASE_W'(1)) & low_mask;

endmodule

// File: rtl/cdt_down.sv
module cdt_down #(
  parameter int COUNT_W = 32,
  parameter int PHASE_W = 7,
  parameter int SHIFT_W = 3,
  parameter int REM_W   = COUNT_W + PHASE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [COUNT_W-1:0] load_val,
  input  logic [SHIFT_W-1:0] load_shift,
  input  logic [PHASE_W-1:0] pad,
  output logic               expired,
  output logic [COUNT_W-1:0] cur_count,
  output logic [REM_W-1:0]   remain
);

  logic [SHIFT_W-1:0] shift_q;
  logic [REM_W-1:0]   load_rem;
  logic [REM_W-1:0]   pad_ext;
  logic [PHASE_W-1:0] round_add;
  logic [REM_W:0]     round_ext;
  logic [REM_W:0]     biased;
  logic [REM_W:0]     quot;

  always_comb begin
    pad_ext               = '0;
    pad_ext[PHASE_W-1:0]  = pad;
    load_rem              = '0;
    load_rem[COUNT_W-1:0] = load_val;
    load_rem              = (load_rem << load_shift) + pad_ext;
    if (load_val == '0) load_rem = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      shift_q <= '0;
      expired <= 1'b0;
    end else begin
      expired <= !load && (remain == REM_W'(1));
      if (load) begin
        remain  <= load_rem;
        shift_q <= load_shift;
      end else if (remain != '0) begin
        remain <= remain - REM_W'(1);
      end
    end
  end

  // Remaining divided ticks, rounded up, using the captured ratio.
  always_comb begin
    round_add              = ~({PHASE_W{1'b1}} << shift_q);
    round_ext              = '0;
    round_ext[PHASE_W-1:0] = round_add;
    biased                 = {1'b0, remain} + round_ext;
    quot                   = biased >> shift_q;
    if (|quot[REM_W:COUNT_W]) cur_count = '1;
    else                      cur_count = quot[COUNT_W-1:0];
  end

endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              timer_expired
);

  localparam int REM_W = COUNT_W + PHASE_W;

  logic [3:0]         cfg_q;
  logic               load;
  logic [COUNT_W-1:0] load_val;
  logic [SHIFT_W-1:0] shift;
  logic [PHASE_W-1:0] pad;
  logic [COUNT_W-1:0] cur_count;
  logic [REM_W-1:0]   remain;

  assign shift = cdt_shift(cfg_q);

  cdt_regs #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .cur_count(cur_count), .cfg_q(cfg_q),
    .load(load), .load_val(load_val), .rdata(reg_rdata)
  );

  cdt_prescale #(.PHASE_W(PHASE_W), .SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst(rst), .shift(shift), .pad(pad)
  );

  cdt_down #(.COUNT_W(COUNT_W), .PHASE_W(PHASE_W), .SHIFT_W(SHIFT_W),
             .REM_W(REM_W)) u_down (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .load_shift(shift), .pad(pad), .expired(timer_expired),
    .cur_count(cur_count), .remain(remain)
  );

endmodule

// File: rtl/cdown_timer_chk.sv
module cdown_timer_chk #(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32,
  parameter int REM_W   = 39
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              timer_expired,
  input logic [REM_W-1:0]  remain
);

  // R6: pulse lasts one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    timer_expired |=> !timer_expired);

  // R6: pulse only follows the last counted cycle
  p_pulse_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(timer_expired) |-> ($past(remain) == REM_W'(1)));

  p_restart_no_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd1) |=> !timer_expired);

  p_zero_stops_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd1 && reg_wdata[COUNT_W-1:0] == '0) |=> (remain == '0));

  p_idle_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 2'd2 && remain == '0) |=> (reg_rdata == '0));

  p_cur_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr != 2'd1 && reg_addr != 2'd0 && remain > REM_W'(1))
      |=> (remain == $past(remain) - REM_W'(1)));

  p_div_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 2'd0) |=> (reg_rdata[DATA_W-1:4] == '0 && !reg_rdata[2]));

endmodule

bind cdown_timer cdown_timer_chk #(.DATA_W(DATA_W), .COUNT_W(COUNT_W), .REM_W(REM_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_expired(timer_expired),
  .remain(remain)
);

// File: tb/cdown_timer_bench.sv
`timescale 1ns/1ps
module cdown_timer_bench;

  localparam int DATA_W  = 32;
  localparam int COUNT_W = 6;
  localparam int CMAX    = (1 << COUNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              timer_expired;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  cdown_timer #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_cdown_timer (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_expired(timer_expired)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h cyc=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int shift_of(input int code);
    int f;
    f = ((code >> 1) & 4) | (code & 3);
    return (f + 1) % 8;
  endfunction

  int cur_d = 2;

  task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
    reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = a;
    step();
    v = reg_rdata;
  endtask

  task automatic write_cfg(input int code);
    logic [31:0] v;
    reg_rd = 1'b0; reg_wr = 1'b1; reg_addr = 2'd0;
    reg_wdata = 32'h5A5A_5A50 | 32'(code);
    step();
    reg_wr = 1'b0;
    read_reg(2'd0, v);
    chk("R3 divide readback", v, 32'(code & 4'hB));
    cur_d = 1 << shift_of(code);
  endtask

  // align: 0 none, 1 boundary, 2 off boundary
  task automatic start(input logic [31:0] data, input int align, output int len);
    int n, p, pad;
    logic [31:0] v;
    n = int'(data) & CMAX;
    if (align != 0 && !(align == 2 && cur_d == 1)) begin
      while ((align == 1) ? (cyc % cur_d != 0) : (cyc % cur_d == 0)) begin
        reg_wr = 1'b0; reg_rd = 1'b0;
        step();
      end
    end
    p   = cyc % 128;
    pad = (cur_d - (p % cur_d)) % cur_d;
    len = (n == 0) ? 0 : n * cur_d + pad;
    reg_rd = 1'b0; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = data;
    step();
    reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = 2'd2;
    chk("R12 no pulse on restart edge", 32'(timer_expired), 32'd0);
  endtask

  // mid kinds: 0 none, 1 cfg write, 2 current-count write, 3 reserved write
  task automatic follow(input int len, input int d, input int stop,
                        input int mid_k, input int mid_kind);
    int exp_rd;
    for (int k = 1; k <= stop; k++) begin
      if (k == mid_k && mid_kind != 0) begin
        reg_rd = 1'b0; reg_wr = 1'b1;
        reg_addr  = (mid_kind == 1) ? 2'd0 : (mid_kind == 2) ? 2'd2 : 2'd3;
        reg_wdata = (mid_kind == 1) ? 32'h0000_000A : 32'h0000_0001;
      end else begin
        reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = 2'd2;
      end
      step();
      chk((k == len) ? "R6 pulse cycle" : "R4/R5 no early or late pulse",
          32'(timer_expired), 32'(k == len));
      if (!(k == mid_k && mid_kind != 0)) begin
        exp_rd = (k <= len) ? (len - k + 1 + d - 1) / d : 0;
        if (exp_rd > CMAX) exp_rd = CMAX;
        chk((k <= len) ? "R7 rounded count" : "R8 idle count", reg_rdata, 32'(exp_rd));
      end
      reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = 2'd2;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int len, len2, d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 expired low", 32'(timer_expired), 32'd0);
    for (int a = 0; a < 4; a++) begin
      read_reg(2'(a), v);
      chk("R1 reset read", v, 32'd0);
    end

    // R2 R4 R5: every cfg code, boundary and off-boundary starts
    for (int code = 0; code < 16; code++) begin
      write_cfg(code);
      for (int al = 1; al <= 2; al++) begin
        for (int n = 1; n <= 3; n += 2) begin
          d = cur_d;
          start(32'(n), al, len);
          follow(len, d, len + 2, 0, 0);
        end
      end
    end

    // R4: upper data bits dropped, start value reads back
    write_cfg(1);
    start(32'hFFFF_FFC5, 1, len);
    follow(len, 4, len + 1, 0, 0);
    read_reg(2'd1, v);
    chk("R4 start readback", v, 32'h5);

    // R7: saturation at ratio 128 with misaligned start of max count
    write_cfg(4'hA);
    start(32'(CMAX), 2, len);
    follow(len, 128, 3, 0, 0);
    start(32'd0, 0, len);

    // R11: cfg change mid-run
    write_cfg(1);
    start(32'd20, 0, len);
    follow(len, 4, len + 2, 10, 1);

    // R10: writes to current count and reserved
    write_cfg(1);
    start(32'd12, 0, len);
    follow(len, 4, len + 2, 5, 2);
    start(32'd12, 0, len);
    follow(len, 4, len + 2, 7, 3);
    read_reg(2'd3, v);
    chk("R10 reserved reads zero", v, 32'd0);

    // R9: zero start stops the timer
    write_cfg(3);
    start(32'd4, 0, len);
    follow(len, cur_d, 5, 0, 0);
    start(32'd0, 0, len2);
    follow(0, cur_d, 4 * cur_d + 40, 0, 0);
    chk("R9 zero start length", 32'(len2), 32'd0);

    // R12: restart on the expiry edge
    write_cfg(0);
    d = cur_d;
    start(32'd6, 0, len);
    follow(len, d, len - 1, 0, 0);
    start(32'd3, 0, len2);
    follow(len2, d, len2 + 2, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule